// File: doc/BRIEF.md
# Write-Back L2 Atomic Ordering Controller

This block is a slice of the control logic in a write-back second-level cache. It decides what happens to reads, writes and atomic operations aimed at a small set of cache lines. Atomics are always system scope, so the cache never executes them itself. It always passes them on to the directory.

The ordering problem appears when an atomic finds its line dirty. The dirty data must reach memory first, so the controller issues a writeback and parks the atomic in a small stall queue. The atomic is not retried cycle after cycle. It sleeps until the writeback acknowledgement for its line arrives, and that event wakes it. The woken atomic is then forwarded, so memory always sees the writeback before the atomic. While the atomic is outstanding at the directory, other requests to that line queue behind it. When the directory answers, the line goes back to invalid, one response goes to the requester, and the queued requests resume in the order they arrived.

Tag and data arrays and the directory sit outside the block. The line state it keeps stands in for the tag array.

Top module: `wbl2_atomic_orderer`

## Requirements
- R1: After synchronous reset every line is invalid, `req_ready` is 1, and neither `dn_valid` nor `rsp_valid` is asserted.
- R2: An atomic (`req_op`=3) accepted for an invalid line drives `dn_valid` with `dn_kind`=2 (atomic), its line and id in the cycle after acceptance. The line becomes atomic-pending.
- R3: An atomic accepted for a dirty line drives `dn_kind`=1 (writeback) carrying the atomic's id in the cycle after acceptance. The line becomes writeback-in-flight, and no atomic for that line leaves the block before the acknowledgement.
- R4: A writeback acknowledgement wakes the atomic stalled on that line. The atomic appears at `dn_*` with `dn_kind`=2 exactly two cycles after the acknowledgement is presented.
- R5: A directory response for an atomic-pending line returns the line to invalid and produces exactly one `rsp_valid` pulse, one cycle later, carrying the atomic's id and line.
- R6: Any request to a line that is writeback-in-flight or atomic-pending, or that has older requests queued, waits in the stall queue. Waiting requests resume only when the line returns to invalid, in arrival order, and each atomic among them takes the line busy again before the next one resumes.
- R7: A wakeup releases only queue entries whose line matches. Entries stalled on other lines stay asleep, and requests to unrelated idle lines proceed at once.
- R8: The stall queue holds DEPTH entries. While it is full, `req_ready` is 0 and no request is lost. Every held request is eventually processed.
- R9: A read (`req_op`=0) to an invalid line is forwarded as `dn_kind`=0 in the next cycle. A read to a dirty line is a local hit with no downstream traffic.
- R10: A partial write (`req_op`=1) or full write (`req_op`=2) produces no downstream traffic and leaves the line dirty. A later atomic to that line therefore starts with a writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 0 read, 1 partial write, 2 full write, 3 atomic |
| req_line | input | LINE_W | Target line index |
| req_id | input | ID_W | Requester tag |
| dn_valid | output | 1 | Downstream request pulse |
| dn_kind | output | 2 | 0 read, 1 writeback, 2 atomic |
| dn_line | output | LINE_W | Line of the downstream request |
| dn_id | output | ID_W | Tag of the originating request |
| wback_ack_valid | input | 1 | Memory acknowledges a writeback |
| wback_ack_line | input | LINE_W | Line being acknowledged |
| dir_rsp_valid | input | 1 | Directory completes an atomic |
| dir_rsp_line | input | LINE_W | Line of the completed atomic |
| rsp_valid | output | 1 | Atomic response to requester |
| rsp_line | output | LINE_W | Line of the response |
| rsp_id | output | ID_W | Tag of the completed atomic |

## Verification
The bench sweeps every line against every starting state (clean, partially written, fully written) and times the atomic path against the acknowledgement. A design that forwarded the atomic together with its writeback, or never forwarded it at all, fails on the count and cycle of downstream pulses. Queued requests to one line are released one directory response at a time. A queue that released everything on the first wakeup would send the second atomic or the read early. A queue that woke every line would forward an atomic still waiting on another line's writeback. Filling the queue to its limit with a further request held at the input catches a design that drops or reorders requests under backpressure.

// File: rtl/wbl2_pkg.sv
package wbl2_pkg;

    typedef enum logic [2:0] {
        LS_I  = 3'd0,
        LS_M  = 3'd1,
        LS_W  = 3'd2,
        LS_A  = 3'd3,
        LS_WI = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_WRITE      = 2'd1,
        OP_WRITE_FULL = 2'd2,
        OP_ATOMIC     = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        DN_READ      = 2'd0,
        DN_WRITEBACK = 2'd1,
        DN_ATOMIC    = 2'd2
    } dn_kind_e;

    function automatic logic is_busy(input line_state_e s);
        return (s == LS_A) || (s == LS_WI);
    endfunction

    function automatic logic is_dirty(input line_state_e s);
        return (s == LS_M) || (s == LS_W);
    endfunction

endpackage

// File: rtl/wbl2_line_table.sv
module wbl2_line_table
    import wbl2_pkg::*;
#(
    parameter int LINE_W = 2,
    parameter int ID_W   = 4,
    localparam int LINES = 1 << LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_valid,
    input  logic [LINE_W-1:0] ack_line,
    input  logic              drsp_valid,
    input  logic [LINE_W-1:0] drsp_line,
    input  logic              upd_valid,
    input  logic [LINE_W-1:0] upd_line,
    input  line_state_e       upd_state,
    input  logic              tbe_wr,
    input  logic [ID_W-1:0]   tbe_id,
    output line_state_e       st_q  [LINES],
    output logic [ID_W-1:0]   tbe_q [LINES]
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]  <= LS_I;
                tbe_q[g] <= '0;
            end else begin
                if (ack_valid && ack_line == LINE_W'(g)) begin
                    st_q[g] <= LS_I;
                end
                if (drsp_valid && drsp_line == LINE_W'(g)) begin
                    st_q[g] <= LS_I;
                end
                if (upd_valid && upd_line == LINE_W'(g)) begin
                    st_q[g] <= upd_state;
                end
                if (tbe_wr && upd_line == LINE_W'(g)) begin
                    tbe_q[g] <= tbe_id;
                end
            end
        end
    end

    // R4
    ack_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> st_q[ack_line] == LS_WI);

    // R5
    rsp_pending_chk: assert property (@(posedge clk) disable iff (rst)
        drsp_valid |-> st_q[drsp_line] == LS_A);

endmodule

// File: rtl/wbl2_stall_queue.sv
module wbl2_stall_queue #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 2,
    parameter int ID_W   = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [1:0]        push_op,
    input  logic [LINE_W-1:0] push_line,
    input  logic [ID_W-1:0]   push_id,
    input  logic              push_woken,
    input  logic              pop_valid,
    input  logic [IDX_W-1:0]  pop_idx,
    input  logic              sleep_valid,
    input  logic [LINE_W-1:0] sleep_line,
    input  logic              wake_a_valid,
    input  logic [LINE_W-1:0] wake_a_line,
    input  logic              wake_b_valid,
    input  logic [LINE_W-1:0] wake_b_line,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_hit,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [1:0]        sel_op,
    output logic [LINE_W-1:0] sel_line,
    output logic [ID_W-1:0]   sel_id,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              any_woken
);

    typedef struct packed {
        logic              vld;
        logic              woken;
        logic [1:0]        op;
        logic [LINE_W-1:0] line;
        logic [ID_W-1:0]   id;
    } slot_t;

    slot_t            q     [DEPTH];
    slot_t            nq    [DEPTH];
    slot_t            up    [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_mid;

    for (genvar g = 0; g < DEPTH; g++) begin : g_up
        if (g < DEPTH - 1) begin : g_mid
            assign up[g] = q[g+1];
        end else begin : g_top
            assign up[g] = '0;
        end
    end

    assign cnt_mid = pop_valid ? cnt_q - CNT_W'(1) : cnt_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            nq[i] = q[i];
            if (pop_valid && IDX_W'(i) >= pop_idx) begin
                nq[i] = up[i];
            end
            if (nq[i].vld && sleep_valid && nq[i].line == sleep_line) begin
                nq[i].woken = 1'b0;
            end
            if (nq[i].vld && ((wake_a_valid && nq[i].line == wake_a_line) ||
                              (wake_b_valid && nq[i].line == wake_b_line))) begin
                nq[i].woken = 1'b1;
            end
            if (push_valid && CNT_W'(i) == cnt_mid) begin
                nq[i] = '{vld: 1'b1, woken: push_woken, op: push_op,
                          line: push_line, id: push_id};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            cnt_q <= cnt_mid + (push_valid ? CNT_W'(1) : CNT_W'(0));
            for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
        end
    end

    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        probe_hit = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (q[i].vld && q[i].woken) begin
                sel_valid = 1'b1;
                sel_idx   = IDX_W'(i);
            end
            if (q[i].vld && q[i].line == probe_line) probe_hit = 1'b1;
        end
    end

    assign sel_op    = q[sel_idx].op;
    assign sel_line  = q[sel_idx].line;
    assign sel_id    = q[sel_idx].id;
    assign count     = cnt_q;
    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign any_woken = sel_valid;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(push_valid && !pop_valid && cnt_q == CNT_W'(DEPTH)));

    // R6
    pop_target_chk: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> (q[pop_idx].vld && q[pop_idx].woken));

endmodule

// File: rtl/wbl2_atomic_orderer.sv
module wbl2_atomic_orderer
    import wbl2_pkg::*;
#(
    parameter int LINE_W   = 2,
    parameter int ID_W     = 4,
    parameter int SB_DEPTH = 4,
    localparam int LINES   = 1 << LINE_W,
    localparam int IDX_W   = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1,
    localparam int CNT_W   = $clog2(SB_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [ID_W-1:0]   req_id,
    output logic              dn_valid,
    output logic [1:0]        dn_kind,
    output logic [LINE_W-1:0] dn_line,
    output logic [ID_W-1:0]   dn_id,
    input  logic              wback_ack_valid,
    input  logic [LINE_W-1:0] wback_ack_line,
    input  logic              dir_rsp_valid,
    input  logic [LINE_W-1:0] dir_rsp_line,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_line,
    output logic [ID_W-1:0]   rsp_id
);

    line_state_e       line_st [LINES];
    logic [ID_W-1:0]   tbe     [LINES];

    logic              sq_probe_hit, sq_sel_valid, sq_full, sq_any_woken;
    logic [IDX_W-1:0]  sq_sel_idx;
    logic [1:0]        sq_sel_op;
    logic [LINE_W-1:0] sq_sel_line;
    logic [ID_W-1:0]   sq_sel_id;
    logic [CNT_W-1:0]  sq_count;

    logic              take;
    req_op_e           cur_op;
    logic [LINE_W-1:0] cur_line;
    logic [ID_W-1:0]   cur_id;
    line_state_e       cur_st;
    logic              wake_here;
    logic              push, push_wk, pop, sleep;
    logic              upd, tbe_wr, dn_go;
    line_state_e       upd_st;
    dn_kind_e          dn_k;

    logic              dn_valid_q, rsp_valid_q;
    dn_kind_e          dn_kind_q;
    logic [LINE_W-1:0] dn_line_q, rsp_line_q;
    logic [ID_W-1:0]   dn_id_q, rsp_id_q;

    assign req_ready = !sq_full && !sq_any_woken;
    assign take      = sq_sel_valid || (req_valid && req_ready);

    always_comb begin
        cur_op    = req_op_e'(req_op);
        cur_line  = req_line;
        cur_id    = req_id;
        if (sq_sel_valid) begin
            cur_op   = req_op_e'(sq_sel_op);
            cur_line = sq_sel_line;
            cur_id   = sq_sel_id;
        end
        cur_st    = line_st[cur_line];
        wake_here = (wback_ack_valid && wback_ack_line == cur_line) ||
                    (dir_rsp_valid && dir_rsp_line == cur_line);
        push   = 1'b0;
        push_wk = 1'b0;
        pop    = 1'b0;
        sleep  = 1'b0;
        upd    = 1'b0;
        upd_st = LS_I;
        tbe_wr = 1'b0;
        dn_go  = 1'b0;
        dn_k   = DN_READ;
        if (take) begin
            if (is_busy(cur_st) || (!sq_sel_valid && sq_probe_hit)) begin
                push    = !sq_sel_valid;
                push_wk = wake_here;
                sleep   = sq_sel_valid;
            end else begin
                unique case (cur_op)
                    OP_ATOMIC: begin
                        upd   = 1'b1;
                        dn_go = 1'b1;
                        sleep = sq_sel_valid;
                        if (cur_st == LS_I) begin
                            upd_st = LS_A;
                            tbe_wr = 1'b1;
                            dn_k   = DN_ATOMIC;
                            pop    = sq_sel_valid;
                        end else begin
                            upd_st = LS_WI;
                            dn_k   = DN_WRITEBACK;
                            push   = !sq_sel_valid;
                        end
                    end
                    OP_WRITE: begin
                        upd    = 1'b1;
                        upd_st = (cur_st == LS_M) ? LS_M : LS_W;
                        pop    = sq_sel_valid;
                    end
                    OP_WRITE_FULL: begin
                        upd    = 1'b1;
                        upd_st = LS_M;
                        pop    = sq_sel_valid;
                    end
                    default: begin
                        dn_go = (cur_st == LS_I);
                        dn_k  = DN_READ;
                        pop   = sq_sel_valid;
                    end
                endcase
            end
        end
    end

    wbl2_line_table #(.LINE_W(LINE_W), .ID_W(ID_W)) i_table (
        .clk        (clk),
        .rst        (rst),
        .ack_valid  (wback_ack_valid),
        .ack_line   (wback_ack_line),
        .drsp_valid (dir_rsp_valid),
        .drsp_line  (dir_rsp_line),
        .upd_valid  (upd),
        .upd_line   (cur_line),
        .upd_state  (upd_st),
        .tbe_wr     (tbe_wr),
        .tbe_id     (cur_id),
        .st_q       (line_st),
        .tbe_q      (tbe)
    );

    wbl2_stall_queue #(.DEPTH(SB_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W)) i_queue (
        .clk          (clk),
        .rst          (rst),
        .push_valid   (push),
        .push_op      (cur_op),
        .push_line    (cur_line),
        .push_id      (cur_id),
        .push_woken   (push_wk),
        .pop_valid    (pop),
        .pop_idx      (sq_sel_idx),
        .sleep_valid  (sleep),
        .sleep_line   (cur_line),
        .wake_a_valid (wback_ack_valid),
        .wake_a_line  (wback_ack_line),
        .wake_b_valid (dir_rsp_valid),
        .wake_b_line  (dir_rsp_line),
        .probe_line   (req_line),
        .probe_hit    (sq_probe_hit),
        .sel_valid    (sq_sel_valid),
        .sel_idx      (sq_sel_idx),
        .sel_op       (sq_sel_op),
        .sel_line     (sq_sel_line),
        .sel_id       (sq_sel_id),
        .count        (sq_count),
        .full         (sq_full),
        .any_woken    (sq_any_woken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid_q  <= 1'b0;
            dn_kind_q   <= DN_READ;
            dn_line_q   <= '0;
            dn_id_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_line_q  <= '0;
            rsp_id_q    <= '0;
        end else begin
            dn_valid_q  <= dn_go;
            dn_kind_q   <= dn_k;
            dn_line_q   <= cur_line;
            dn_id_q     <= cur_id;
            rsp_valid_q <= dir_rsp_valid;
            rsp_line_q  <= dir_rsp_line;
            rsp_id_q    <= tbe[dir_rsp_line];
        end
    end

    assign dn_valid  = dn_valid_q;
    assign dn_kind   = dn_kind_q;
    assign dn_line   = dn_line_q;
    assign dn_id     = dn_id_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_line  = rsp_line_q;
    assign rsp_id    = rsp_id_q;

    // R3
    atomic_only_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_kind == DN_ATOMIC) |-> line_st[dn_line] == LS_A);

    // R3
    writeback_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && dn_kind == DN_WRITEBACK) |-> line_st[dn_line] == LS_WI);

    // R5
    rsp_line_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> line_st[rsp_line] == LS_I);

    // R8
    full_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
        (sq_count == CNT_W'(SB_DEPTH)) |-> !req_ready);

    // R6
    replay_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        sq_sel_valid |-> !is_busy(line_st[sq_sel_line]));

endmodule

// File: tb/test_wbl2_atomic_orderer.sv
`timescale 1ns/1ps
module test_wbl2_atomic_orderer;
    localparam int LW = 2;
    localparam int IW = 4;
    localparam int D  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [LW-1:0] req_line = '0;
    logic [IW-1:0] req_id = '0;
    logic          dn_valid;
    logic [1:0]    dn_kind;
    logic [LW-1:0] dn_line;
    logic [IW-1:0] dn_id;
    logic          wback_ack_valid = 1'b0;
    logic [LW-1:0] wback_ack_line = '0;
    logic          dir_rsp_valid = 1'b0;
    logic [LW-1:0] dir_rsp_line = '0;
    logic          rsp_valid;
    logic [LW-1:0] rsp_line;
    logic [IW-1:0] rsp_id;

    always #4 clk = ~clk;

    wbl2_atomic_orderer #(.LINE_W(LW), .ID_W(IW), .SB_DEPTH(D)) i_wbl2_atomic_orderer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_line(req_line), .req_id(req_id),
        .dn_valid(dn_valid), .dn_kind(dn_kind), .dn_line(dn_line), .dn_id(dn_id),
        .wback_ack_valid(wback_ack_valid), .wback_ack_line(wback_ack_line),
        .dir_rsp_valid(dir_rsp_valid), .dir_rsp_line(dir_rsp_line),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_id(rsp_id)
    );

    int nchk = 0, nerr = 0, cyc = 0;
    int ln = 0, rn = 0;
    int lk [256], ll [256], li [256], lc [256];
    int rl [64], ri [64];
    int drive_cyc, ack_cyc;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && dn_valid && ln < 256) begin
            lk[ln] = dn_kind; ll[ln] = dn_line; li[ln] = dn_id; lc[ln] = cyc;
            ln++;
        end
        if (!rst && rsp_valid && rn < 64) begin
            rl[rn] = rsp_line; ri[rn] = rsp_id;
            rn++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int find_dn(input int k, input int l, input int id, input int from);
        for (int i = from; i < ln; i++)
            if (lk[i] == k && ll[i] == l && li[i] == id) return i;
        return -1;
    endfunction

    task automatic send(input int op, input int line, input int id);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_line = LW'(line); req_id = IW'(id);
        drive_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input int line);
        @(negedge clk);
        wback_ack_valid = 1'b1; wback_ack_line = LW'(line); ack_cyc = cyc;
        @(negedge clk);
        wback_ack_valid = 1'b0;
    endtask

    task automatic drsp(input int line);
        @(negedge clk);
        dir_rsp_valid = 1'b1; dir_rsp_line = LW'(line);
        @(negedge clk);
        dir_rsp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base, rb, a, t0, id, i2, i3, i4, i5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", req_ready, 1);
        chk("R1 dn_valid", dn_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);

        // R2 R3 R4 R5 R10 sweep: every line, every starting state
        for (int L = 0; L < 4; L++) begin
            for (int pre = 0; pre < 3; pre++) begin
                id = (L * 3 + pre + 1) % 16;
                base = ln;
                if (pre == 1) send(1, L, 0);
                if (pre == 2) send(2, L, 0);
                idle(2);
                // R10 writes emit nothing downstream
                if (pre != 0) chk("R10 write silent", ln - base, 0);
                send(3, L, id);
                t0 = drive_cyc;
                idle(3);
                chk("R2/R3 one downstream pulse", ln - base, 1);
                if (pre == 0) begin
                    chk("R2 kind atomic", lk[base], 2);
                    chk("R2 line", ll[base], L);
                    chk("R2 id", li[base], id);
                    chk("R2 latency", lc[base] - t0, 1);
                end else begin
                    chk("R3 kind writeback", lk[base], 1);
                    chk("R3 id", li[base], id);
                    chk("R3 latency", lc[base] - t0, 1);
                    idle(6);
                    chk("R3 no atomic before ack", ln - base, 1);
                    ack(L);
                    a = ack_cyc;
                    idle(4);
                    chk("R4 atomic after ack", ln - base, 2);
                    chk("R4 kind atomic", lk[base + 1], 2);
                    chk("R4 id", li[base + 1], id);
                    chk("R4 latency", lc[base + 1] - a, 2);
                end
                rb = rn;
                drsp(L);
                idle(3);
                chk("R5 one response", rn - rb, 1);
                chk("R5 rsp id", ri[rb], id);
                chk("R5 rsp line", rl[rb], L);
                idle(3);
                chk("R5 exactly one response", rn - rb, 1);
            end
        end

        // R9 reads
        base = ln;
        send(0, 2, 1);
        idle(3);
        chk("R9 read miss forwarded", ln - base, 1);
        chk("R9 read kind", lk[base], 0);
        chk("R9 read id", li[base], 1);
        send(1, 2, 0);
        base = ln;
        send(0, 2, 2);
        idle(3);
        chk("R9 read hit local", ln - base, 0);
        send(3, 2, 3);
        idle(3);
        ack(2);
        idle(4);
        drsp(2);
        idle(4);

        // R6 ordering behind a busy line, R7 unrelated line proceeds
        base = ln; rb = rn;
        send(1, 1, 0);
        send(3, 1, 5);
        send(3, 1, 6);
        send(0, 1, 7);
        send(0, 2, 8);
        idle(3);
        chk("R7 idle line read proceeds", find_dn(0, 2, 8, base) >= 0, 1);
        chk("R6 only wb and read so far", ln - base, 2);
        ack(1);
        idle(4);
        chk("R6 first atomic released", find_dn(2, 1, 5, base) >= 0, 1);
        chk("R6 second atomic still held", find_dn(2, 1, 6, base), -1);
        chk("R6 read still held", find_dn(0, 1, 7, base), -1);
        drsp(1);
        idle(4);
        chk("R6 second atomic after rsp", find_dn(2, 1, 6, base) >= 0, 1);
        chk("R6 read held behind second atomic", find_dn(0, 1, 7, base), -1);
        drsp(1);
        idle(4);
        chk("R6 read released last", find_dn(0, 1, 7, base) >= 0, 1);
        chk("R5 rsp order first", ri[rb], 5);
        chk("R5 rsp order second", ri[rb + 1], 6);

        // R7 wake releases matching line only
        base = ln;
        send(2, 3, 0);
        send(2, 0, 0);
        send(3, 3, 9);
        send(3, 0, 10);
        send(0, 3, 11);
        idle(3);
        ack(0);
        idle(4);
        chk("R7 matching atomic released", find_dn(2, 0, 10, base) >= 0, 1);
        chk("R7 other line atomic held", find_dn(2, 3, 9, base), -1);
        chk("R7 other line read held", find_dn(0, 3, 11, base), -1);
        ack(3);
        idle(4);
        chk("R7 second line atomic released", find_dn(2, 3, 9, base) >= 0, 1);
        drsp(0);
        drsp(3);
        idle(4);
        chk("R7 read after line 3 done", find_dn(0, 3, 11, base) >= 0, 1);

        // R8 full queue backpressure, nothing lost
        base = ln;
        send(2, 0, 0);
        send(3, 0, 1);
        send(0, 0, 2);
        send(0, 0, 3);
        send(0, 0, 4);
        idle(1);
        chk("R8 ready low when full", req_ready, 0);
        fork
            send(0, 0, 5);
        join_none
        idle(5);
        chk("R8 still full", req_ready, 0);
        chk("R8 no read leaks", find_dn(0, 0, 2, base), -1);
        ack(0);
        idle(6);
        chk("R8 atomic released", find_dn(2, 0, 1, base) >= 0, 1);
        drsp(0);
        idle(12);
        i2 = find_dn(0, 0, 2, base);
        i3 = find_dn(0, 0, 3, base);
        i4 = find_dn(0, 0, 4, base);
        i5 = find_dn(0, 0, 5, base);
        chk("R8 read 2 present", i2 >= 0, 1);
        chk("R8 read 5 present", i5 >= 0, 1);
        chk("R8 order 2<3", i2 < i3, 1);
        chk("R8 order 3<4", i3 < i4, 1);
        chk("R8 order 4<5", i4 < i5, 1);
        chk("R8 ready restored", req_ready, 1);

        finish_run();
    end
endmodule